// File: doc/BRIEF.md
# Delay Line Step Controller

This block sits between a register interface and a bank of programmable delay elements. Each element has a small tap-select input that moves one tap per step pulse. Software writes single-cycle command pulses: step once, step a counted burst, or restore the default tap. The block turns each command into a timed sequence of step pulses. It holds a stable direction and target address on its outputs for the whole sequence.

Every channel owns two delay elements, addressed through a unit ID. The capture-block delay of channel c answers to ID 4*c and the input-block delay to ID 4*c+1. The controller keeps a shadow copy of the tap position of every element. It uses that copy to refuse any step that would run past tap 0 or past the top tap. A refused step raises a sticky end-of-range flag, which stays set until a status-clear pulse. A busy flag tells software when the next command can be written.

Top module: `dly_step_ctrl`

## Requirements
- R1: The unit ID selects element 2*c+b when bit 1 is 0, bit 0 is b, and the channel field c (ID bits above bit 1) is below NUM_CH. Any other ID is ignored: busy stays 0 and no pulse appears. While a command runs, `target_id_o` shows the accepted ID.
- R2: `step_dir_i` = 0 raises the tap position and 1 lowers it, for single and burst commands alike. `dir_o` shows the latched direction while busy.
- R3: A single-step command produces exactly one step pulse. The pulse comes in the first free step slot after acceptance, which is the cycle after acceptance when no step occurred in the previous 3 cycles.
- R4: A burst command produces N step slots, where N is the 7-bit `burst_len_i` value. Slots follow one another exactly STEP_GAP cycles apart.
- R5: Any two step or load pulses, including pulses from consecutive commands, are at least STEP_GAP (4) cycles apart. A command accepted sooner waits for the gap to expire.
- R6: A default command produces one `load_o` pulse and no step pulse. It sets the element's tap position to DEFAULT_TAP.
- R7: `busy_o` rises the cycle after a command is accepted and stays 1 through the cycle of its last slot. It is 0 in the cycle that follows.
- R8: A step that would take the element below tap 0 or above TAP_MAX is suppressed: the slot passes without a pulse and the tap is unchanged.
- R9: `end_flag_o` becomes 1 the cycle after a suppressed step. It stays 1 until a `clr_status_i` pulse, after which it reads 0.
- R10: A command that arrives while `busy_o` is 1, including in the last busy cycle, is dropped. It has no effect on the running sequence, and no sequence follows it.
- R11: A burst with N = 0 completes at once: busy stays 0 and no pulse appears.
- R12: When several command inputs are high together, default wins over burst and burst wins over single step. A burst with N = 0 therefore cancels a simultaneous single step.
- R13: After reset, busy, end flag, step and load outputs are 0, and every element's tap position is DEFAULT_TAP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| cmd_single_i | input | 1 | Single-step command pulse |
| cmd_burst_i | input | 1 | Burst command pulse |
| cmd_default_i | input | 1 | Restore-default command pulse |
| clr_status_i | input | 1 | Clears the sticky end-of-range flag |
| unit_id_i | input | UID_W | Target unit ID |
| step_dir_i | input | 1 | Step direction, 0 up, 1 down |
| burst_len_i | input | CNT_W | Step count of a burst |
| step_o | output | 1 | One-cycle step pulse to the selected element |
| load_o | output | 1 | One-cycle restore-default pulse |
| dir_o | output | 1 | Latched step direction |
| target_id_o | output | UID_W | Latched unit ID of the running command |
| busy_o | output | 1 | Adjustment in progress |
| end_flag_o | output | 1 | Sticky end-of-range flag |

## Verification
The bench builds the block with two channels (four elements), a top tap of 12 and a default tap of 5. With these values, short bursts reach both range ends from the default position. This lets the sweep cover every element, both directions and every burst length from 0 to 14, plus full 127-step bursts that pin an element at each end. The small ID space also lets a few IDs cover every kind of invalid address. Back-to-back commands and commands dropped during the last busy cycle exercise the gap that carries across commands.

// File: rtl/dly_step_pkg.sv
package dly_step_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_STEP = 2'd1,
    OP_LOAD = 2'd2
  } dly_op_e;
endpackage

// File: rtl/dly_cmd_decode.sv
module dly_cmd_decode
  import dly_step_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int UID_W  = 9,
  parameter int CNT_W  = 7,
  localparam int ELEM_W = $clog2(2 * NUM_CH)
) (
  input  logic              cmd_single_i,
  input  logic              cmd_burst_i,
  input  logic              cmd_default_i,
  input  logic [UID_W-1:0]  unit_id_i,
  input  logic [CNT_W-1:0]  burst_len_i,
  output logic              req_o,
  output dly_op_e           op_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [ELEM_W-1:0] elem_o
);
  localparam int CHF_W = UID_W - 2;

  logic [CHF_W-1:0] chan;
  logic             id_ok;

  assign chan   = unit_id_i[UID_W-1:2];
  assign id_ok  = (unit_id_i[1] == 1'b0) && (int'(chan) < NUM_CH);
  assign elem_o = {chan[ELEM_W-2:0], unit_id_i[0]};

  // priority: default, then burst, then single
  always_comb begin
    op_o  = OP_IDLE;
    cnt_o = '0;
    if (cmd_default_i) begin
      op_o  = OP_LOAD;
      cnt_o = CNT_W'(1);
    end else if (cmd_burst_i) begin
      op_o  = OP_STEP;
      cnt_o = burst_len_i;
    end else if (cmd_single_i) begin
      op_o  = OP_STEP;
      cnt_o = CNT_W'(1);
    end
  end

  assign req_o = id_ok && (op_o != OP_IDLE) && (cnt_o != '0);
endmodule

// File: rtl/dly_step_seq.sv
module dly_step_seq
  import dly_step_pkg::*;
#(
  parameter int UID_W    = 9,
  parameter int CNT_W    = 7,
  parameter int ELEM_W   = 6,
  parameter int STEP_GAP = 4,
  localparam int GAP_W   = $clog2(STEP_GAP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  dly_op_e           op_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [ELEM_W-1:0] elem_i,
  input  logic [UID_W-1:0]  uid_i,
  input  logic              dir_i,
  input  logic              step_ok_i,
  output logic              busy_o,
  output logic              dir_o,
  output logic [ELEM_W-1:0] elem_o,
  output logic [UID_W-1:0]  uid_o,
  output logic              step_fire_o,
  output logic              load_fire_o,
  output logic              blocked_o
);
  localparam logic [GAP_W-1:0] GAP_RELOAD = GAP_W'(STEP_GAP - 1);

  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  dly_op_e           op_q;
  logic              dir_q;
  logic [ELEM_W-1:0] elem_q;
  logic [UID_W-1:0]  uid_q;
  logic              accept, slot;

  assign accept = !busy_q && req_i;
  assign slot   = busy_q && (gap_q == '0);

  // next state
  always_comb begin
    busy_d = busy_q;
    rem_d  = rem_q;
    gap_d  = gap_q;
    if (slot) begin
      gap_d = GAP_RELOAD;
      rem_d = rem_q - CNT_W'(1);
      if (rem_q == CNT_W'(1)) busy_d = 1'b0;
    end else if (gap_q != '0) begin
      gap_d = gap_q - GAP_W'(1);
    end
    if (accept) begin
      busy_d = 1'b1;
      rem_d  = cnt_i;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      gap_q  <= '0;
    end else begin
      busy_q <= busy_d;
      rem_q  <= rem_d;
      gap_q  <= gap_d;
    end
  end

  // command latch, enabled on acceptance only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      dir_q  <= 1'b0;
      elem_q <= '0;
      uid_q  <= '0;
    end else if (accept) begin
      op_q   <= op_i;
      dir_q  <= dir_i;
      elem_q <= elem_i;
      uid_q  <= uid_i;
    end
  end

  assign busy_o      = busy_q;
  assign dir_o       = dir_q;
  assign elem_o      = elem_q;
  assign uid_o       = uid_q;
  assign step_fire_o = slot && (op_q == OP_STEP) && step_ok_i;
  assign load_fire_o = slot && (op_q == OP_LOAD);
  assign blocked_o   = slot && (op_q == OP_STEP) && !step_ok_i;

  // spacing checker: cycles since the last pulse
  logic [GAP_W:0] since_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          since_q <= (GAP_W+1)'(STEP_GAP - 1);
    else if (step_fire_o || load_fire_o) since_q <= '0;
    else if (since_q != (GAP_W+1)'(STEP_GAP - 1)) since_q <= since_q + 1'b1;
  end

  p_pulse_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire_o || load_fire_o) |-> (since_q >= (GAP_W+1)'(STEP_GAP - 1)));

  p_busy_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && req_i) |=> ($stable(uid_q) && $stable(dir_q) && $stable(op_q) && $stable(elem_q)));
endmodule

// File: rtl/dly_tap_model.sv
module dly_tap_model #(
  parameter int NUM_ELEM    = 64,
  parameter int ELEM_W      = 6,
  parameter int TAP_MAX     = 127,
  parameter int DEFAULT_TAP = 64,
  localparam int TAP_W      = $clog2(TAP_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ELEM_W-1:0] elem_i,
  input  logic              dir_i,
  input  logic              step_fire_i,
  input  logic              load_fire_i,
  output logic              step_ok_o
);
  localparam logic [TAP_W-1:0] TOP_TAP = TAP_W'(TAP_MAX);
  localparam logic [TAP_W-1:0] DEF_TAP = TAP_W'(DEFAULT_TAP);

  logic [TAP_W-1:0] tap_q [NUM_ELEM];
  logic [TAP_W-1:0] tap_sel;

  for (genvar e = 0; e < NUM_ELEM; e++) begin : g_elem
    logic             hit;
    logic [TAP_W-1:0] tap_d;

    assign hit = (int'(elem_i) == e) && (step_fire_i || load_fire_i);

    always_comb begin
      if (load_fire_i)  tap_d = DEF_TAP;
      else if (dir_i)   tap_d = tap_q[e] - TAP_W'(1);
      else              tap_d = tap_q[e] + TAP_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   tap_q[e] <= DEF_TAP;
      else if (hit) tap_q[e] <= tap_d;
    end

    p_tap_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tap_q[e] <= TOP_TAP);
  end

  always_comb begin
    tap_sel = '0;
    for (int e = 0; e < NUM_ELEM; e++)
      if (int'(elem_i) == e) tap_sel = tap_q[e];
  end

  assign step_ok_o = dir_i ? (tap_sel != '0) : (tap_sel != TOP_TAP);
endmodule

// File: rtl/dly_step_ctrl.sv
module dly_step_ctrl
  import dly_step_pkg::*;
#(
  parameter int NUM_CH      = 32,
  parameter int UID_W       = 9,
  parameter int CNT_W       = 7,
  parameter int TAP_MAX     = 127,
  parameter int DEFAULT_TAP = 64,
  parameter int STEP_GAP    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_single_i,
  input  logic             cmd_burst_i,
  input  logic             cmd_default_i,
  input  logic             clr_status_i,
  input  logic [UID_W-1:0] unit_id_i,
  input  logic             step_dir_i,
  input  logic [CNT_W-1:0] burst_len_i,
  output logic             step_o,
  output logic             load_o,
  output logic             dir_o,
  output logic [UID_W-1:0] target_id_o,
  output logic             busy_o,
  output logic             end_flag_o
);
  localparam int NUM_ELEM = 2 * NUM_CH;
  localparam int ELEM_W   = $clog2(NUM_ELEM);

  logic              req;
  dly_op_e           op;
  logic [CNT_W-1:0]  cnt;
  logic [ELEM_W-1:0] elem_dec, elem_run;
  logic              step_ok, step_fire, load_fire, blocked;
  logic              end_q, end_d;

  dly_cmd_decode #(
    .NUM_CH (NUM_CH),
    .UID_W  (UID_W),
    .CNT_W  (CNT_W)
  ) u_decode (
    .cmd_single_i  (cmd_single_i),
    .cmd_burst_i   (cmd_burst_i),
    .cmd_default_i (cmd_default_i),
    .unit_id_i     (unit_id_i),
    .burst_len_i   (burst_len_i),
    .req_o         (req),
    .op_o          (op),
    .cnt_o         (cnt),
    .elem_o        (elem_dec)
  );

  dly_step_seq #(
    .UID_W    (UID_W),
    .CNT_W    (CNT_W),
    .ELEM_W   (ELEM_W),
    .STEP_GAP (STEP_GAP)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req),
    .op_i        (op),
    .cnt_i       (cnt),
    .elem_i      (elem_dec),
    .uid_i       (unit_id_i),
    .dir_i       (step_dir_i),
    .step_ok_i   (step_ok),
    .busy_o      (busy_o),
    .dir_o       (dir_o),
    .elem_o      (elem_run),
    .uid_o       (target_id_o),
    .step_fire_o (step_fire),
    .load_fire_o (load_fire),
    .blocked_o   (blocked)
  );

  dly_tap_model #(
    .NUM_ELEM    (NUM_ELEM),
    .ELEM_W      (ELEM_W),
    .TAP_MAX     (TAP_MAX),
    .DEFAULT_TAP (DEFAULT_TAP)
  ) u_taps (
    .clk         (clk),
    .rst_n       (rst_n),
    .elem_i      (elem_run),
    .dir_i       (dir_o),
    .step_fire_i (step_fire),
    .load_fire_i (load_fire),
    .step_ok_o   (step_ok)
  );

  // sticky end-of-range flag; a new event wins over a clear
  always_comb begin
    end_d = end_q;
    if (clr_status_i) end_d = 1'b0;
    if (blocked)      end_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) end_q <= 1'b0;
    else        end_q <= end_d;
  end

  assign step_o     = step_fire;
  assign load_o     = load_fire;
  assign end_flag_o = end_q;

  p_end_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (end_q && !clr_status_i) |=> end_q);

  p_end_on_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> end_q);
endmodule

// File: tb/dly_step_ctrl_bench.sv
`timescale 1ns/1ps
module dly_step_ctrl_bench;
  localparam int NCH  = 2;
  localparam int TMAX = 12;
  localparam int TDEF = 5;
  localparam int GAP  = 4;

  logic       clk;
  logic       rst_n;
  logic       cmd_single, cmd_burst, cmd_default, clr_status;
  logic [8:0] unit_id;
  logic       step_dir;
  logic [6:0] burst_len;
  logic       step_o, load_o, dir_o, busy_o, end_flag_o;
  logic [8:0] target_id_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int last_slot = -100;
  int tap [2*NCH];
  bit exp_end = 0;

  dly_step_ctrl #(
    .NUM_CH (NCH), .UID_W (9), .CNT_W (7),
    .TAP_MAX (TMAX), .DEFAULT_TAP (TDEF), .STEP_GAP (GAP)
  ) u_dly_step_ctrl (
    .clk (clk), .rst_n (rst_n),
    .cmd_single_i (cmd_single), .cmd_burst_i (cmd_burst),
    .cmd_default_i (cmd_default), .clr_status_i (clr_status),
    .unit_id_i (unit_id), .step_dir_i (step_dir), .burst_len_i (burst_len),
    .step_o (step_o), .load_o (load_o), .dir_o (dir_o),
    .target_id_o (target_id_o), .busy_o (busy_o), .end_flag_o (end_flag_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
  endtask

  task automatic run_cmd(input bit s, input bit b, input bit d, input logic [8:0] id,
                         input bit dir, input int n, input bit intrude);
    bit    ok, allowed;
    int    rem, e;
    string lbl;
    cmd_single = s; cmd_burst = b; cmd_default = d;
    unit_id = id; step_dir = dir; burst_len = 7'(n);
    tick();
    cmd_single = 0; cmd_burst = 0; cmd_default = 0;
    ok  = (id[1] == 1'b0) && (int'(id[8:2]) < NCH);
    rem = d ? 1 : (b ? n : (s ? 1 : 0));
    if (!ok) rem = 0;
    e   = 2 * int'(id[8:2]) + int'(id[0]);
    lbl = b ? "R4 burst step" : "R3 single step";
    if (rem == 0) begin
      chk(ok ? "R11 no busy" : "R1 bad id no busy", busy_o, 0);
      chk("R11 no step", step_o, 0);
      chk("R12 no load", load_o, 0);
      return;
    end
    while (rem > 0) begin
      chk("R7 busy high", busy_o, 1);
      chk("R9 end flag", end_flag_o, exp_end);
      chk("R1 target id", target_id_o, id);
      if (!d) chk("R2 dir out", dir_o, dir);
      if (cyc - last_slot >= GAP) begin
        last_slot = cyc;
        rem--;
        if (d) begin
          chk("R6 load pulse", load_o, 1);
          chk("R6 no step", step_o, 0);
          tap[e] = TDEF;
        end else begin
          allowed = dir ? (tap[e] > 0) : (tap[e] < TMAX);
          chk(allowed ? lbl : "R8 suppressed", step_o, allowed);
          chk("R12 no load", load_o, 0);
          if (allowed) tap[e] += dir ? -1 : 1;
          else exp_end = 1;
        end
      end else begin
        chk("R5 gap no step", step_o, 0);
        chk("R5 gap no load", load_o, 0);
      end
      if (intrude && rem == 0) begin
        cmd_single = 1; unit_id = id ^ 9'h001; step_dir = !dir;
      end
      tick();
      cmd_single = 0;
    end
    chk(intrude ? "R10 busy after drop" : "R7 busy low", busy_o, 0);
    chk("R9 end flag after", end_flag_o, exp_end);
    chk("R7 no step after", step_o, 0);
  endtask

  task automatic clear_end();
    clr_status = 1;
    tick();
    clr_status = 0;
    exp_end = 0;
    chk("R9 cleared", end_flag_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [8:0] ids [4];
    logic [8:0] badids [7];
    ids = '{9'd0, 9'd1, 9'd4, 9'd5};
    badids = '{9'd2, 9'd3, 9'd6, 9'd7, 9'd8, 9'd13, 9'd511};
    rst_n = 0; cmd_single = 0; cmd_burst = 0; cmd_default = 0; clr_status = 0;
    unit_id = '0; step_dir = 0; burst_len = '0;
    for (int i = 0; i < 2*NCH; i++) tap[i] = TDEF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    chk("R13 busy reset", busy_o, 0);
    chk("R13 end reset", end_flag_o, 0);
    chk("R13 step reset", step_o, 0);
    chk("R13 load reset", load_o, 0);

    // R3: single steps on every element, both directions, back to back
    for (int k = 0; k < 4; k++) begin
      run_cmd(1, 0, 0, ids[k], 0, 0, 0);
      run_cmd(1, 0, 0, ids[k], 1, 0, 0);
    end

    // R4/R8: burst past the top tap from the reset default (R13)
    run_cmd(0, 1, 0, 9'd0, 0, 10, 0);
    clear_end();
    run_cmd(0, 1, 0, 9'd5, 1, 15, 0);
    clear_end();

    // R6: restore default, then exactly reach the top without end
    run_cmd(0, 0, 1, 9'd5, 0, 0, 0);
    run_cmd(0, 1, 0, 9'd5, 0, TMAX - TDEF, 0);
    run_cmd(1, 0, 0, 9'd5, 0, 0, 0);
    clear_end();

    // R1: invalid unit IDs are ignored
    for (int k = 0; k < 7; k++) run_cmd(1, 0, 0, badids[k], 0, 0, 0);
    // R11: zero-length burst
    run_cmd(0, 1, 0, 9'd4, 0, 0, 0);
    // R12: priority between simultaneous commands
    run_cmd(1, 1, 1, 9'd1, 0, 6, 0);
    run_cmd(1, 1, 0, 9'd4, 0, 3, 0);
    run_cmd(1, 1, 0, 9'd4, 1, 0, 0);
    // R10: commands dropped in the last busy cycle
    run_cmd(0, 1, 0, 9'd0, 1, 2, 1);
    run_cmd(1, 0, 0, 9'd1, 1, 0, 1);

    // sweep: every element, both directions, lengths 0..14
    for (int k = 0; k < 4; k++) begin
      for (int dr = 0; dr < 2; dr++) begin
        for (int n = 0; n < 15; n++) run_cmd(0, 1, 0, ids[k], dr[0], n, (n % 3) == 0);
        clear_end();
      end
    end

    // full-length bursts pinning an element at each end
    run_cmd(0, 1, 0, 9'd1, 0, 127, 0);
    run_cmd(0, 1, 0, 9'd1, 1, 127, 0);
    clear_end();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule